// File: doc/BRIEF.md
# Expansion I/O Page Decoder with Override

This block sits on the host expansion bus. It watches the 20-bit address bus and the active-low CPU data strobe. It produces an override strobe for the motherboard's master decoder. For unclaimed accesses the override simply copies the data strobe. When an access falls on an address the block claims, the override is held high. The motherboard then sees no strobe and its own decoding stays off for that access.

The on-board I/O area is a 16 KB region at 18000–1BFFF, split into 256-byte pages. The first page, 18000–180FF, holds the registers the motherboard hardware really uses, and it is never claimed. Each of the other 63 pages can be handed to an external peripheral through a bit in an enable mask. That peripheral then gets its own active-low chip select. A separate enable lets the block also take over the 16 KB ROM-slot window at 0C000–0FFFF, so that writable hardware can replace the slot. The decode is purely combinational. Only the configuration is registered.

Top module: `exp_page_decoder`

## Requirements
- R1: After reset every page and the ROM window are disabled. No chip select asserts, and `ovr_n` equals `strobe_n` for every address.
- R2: For any access the block does not claim, `ovr_n` equals `strobe_n`. This covers addresses outside both regions and addresses in disabled pages.
- R3: Page p (1..63) covers 18000 + p·256 up to 18000 + p·256 + FF. When mask bit p−1 is set and `strobe_n` is low on such an address, `page_sel_n[p-1]` is low and `ovr_n` is high.
- R4: Addresses 18000–180FF are never claimed, whatever the configuration.
- R5: An access to a page whose mask bit is clear asserts no chip select and leaves `ovr_n` low while `strobe_n` is low.
- R6: Addresses outside 18000–1BFFF are never decoded as pages. This includes 17FFF, 1C000 and 1C100.
- R7: While `strobe_n` is high, every chip select is high and `ovr_n` is high.
- R8: When the ROM enable is set, an access to 0C000–0FFFF with `strobe_n` low drives `rom_sel_n` low and `ovr_n` high. When it is clear, or when the address lies outside the window, `rom_sel_n` stays high.
- R9: `cfg_page_en` and `cfg_rom_en` are taken on a rising clock edge only while `cfg_load` is high. At all other times they have no effect on the outputs.
- R10: At most one chip select (pages and ROM together) is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | CPU address bus |
| strobe_n | input | 1 | CPU data strobe, active low |
| cfg_load | input | 1 | Load strobe for the configuration |
| cfg_page_en | input | 63 | Page enables; bit p−1 enables page p |
| cfg_rom_en | input | 1 | Enable for the ROM-window claim |
| ovr_n | output | 1 | Override strobe to the motherboard decoder |
| page_sel_n | output | 63 | Active-low page chip selects; bit p−1 for page p |
| rom_sel_n | output | 1 | Active-low chip select for the ROM window |

## Verification
Accesses are made to the first, an interior and the last claimable page, including the top byte 1BFFF. Each one confirms that the page index maps to the right select bit and to no other. Accesses to the reserved first page and to addresses just below and just above the I/O region show that claims never leak past the region edges. Accesses to a disabled page next to an enabled one show that the mask, and not the address alone, decides a claim. The ROM window is probed at both of its ends and one byte outside each, with the enable set and with it clear. Configuration values presented without a load pulse, and again in the cycle before the loading edge, show that the register only changes on that edge.

// File: rtl/exp_dec_pkg.sv
package exp_dec_pkg;
  localparam int ADDR_W = 20;
  typedef logic [ADDR_W-1:0] addr_t;

  // True when a lies in the aligned 2**span window starting at base.
  function automatic logic in_window(addr_t a, addr_t base, int span);
    addr_t diff;
    diff = (a ^ base) >> span;
    return diff == '0;
  endfunction
endpackage

// File: rtl/exp_cfg_reg.sv
module exp_cfg_reg #(
  parameter int N = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] page_en_d,
  input  logic         rom_en_d,
  output logic [N-1:0] page_en_q,
  output logic         rom_en_q
);
  logic [N-1:0] page_en_nx;
  logic         rom_en_nx;

  always_comb begin
    page_en_nx = page_en_q;
    rom_en_nx  = rom_en_q;
    if (load) begin
      page_en_nx = page_en_d;
      rom_en_nx  = rom_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_en_q <= '0;
      rom_en_q  <= 1'b0;
    end else begin
      page_en_q <= page_en_nx;
      rom_en_q  <= rom_en_nx;
    end
  end
endmodule

// File: rtl/exp_page_match.sv
module exp_page_match
  import exp_dec_pkg::*;
#(
  parameter addr_t IO_BASE      = 20'h18000,
  parameter int    IO_SPAN_BITS = 14,
  parameter int    PAGE_BITS    = 8,
  localparam int   IDX_W        = IO_SPAN_BITS - PAGE_BITS,
  localparam int   N            = (1 << IDX_W) - 1
) (
  input  addr_t        addr,
  input  logic [N-1:0] en,
  output logic [N-1:0] hit
);
  logic             in_io;
  logic [IDX_W-1:0] idx;

  assign in_io = in_window(addr, IO_BASE, IO_SPAN_BITS);
  assign idx   = addr[IO_SPAN_BITS-1:PAGE_BITS];

  // Index 0 is the reserved on-board page, so compare slot g against g+1.
  for (genvar g = 0; g < N; g++) begin : g_page
    assign hit[g] = in_io && en[g] && (idx == IDX_W'(g + 1));
  end
endmodule

// File: rtl/exp_rom_match.sv
module exp_rom_match
  import exp_dec_pkg::*;
#(
  parameter addr_t ROM_BASE      = 20'h0C000,
  parameter int    ROM_SPAN_BITS = 14
) (
  input  addr_t addr,
  input  logic  en,
  output logic  hit
);
  assign hit = en && in_window(addr, ROM_BASE, ROM_SPAN_BITS);
endmodule

// File: rtl/exp_page_decoder.sv
module exp_page_decoder
  import exp_dec_pkg::*;
#(
  parameter addr_t IO_BASE       = 20'h18000,
  parameter int    IO_SPAN_BITS  = 14,
  parameter int    PAGE_BITS     = 8,
  parameter addr_t ROM_BASE      = 20'h0C000,
  parameter int    ROM_SPAN_BITS = 14,
  localparam int   CLAIM_N       = (1 << (IO_SPAN_BITS - PAGE_BITS)) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               strobe_n,
  input  logic               cfg_load,
  input  logic [CLAIM_N-1:0] cfg_page_en,
  input  logic               cfg_rom_en,
  output logic               ovr_n,
  output logic [CLAIM_N-1:0] page_sel_n,
  output logic               rom_sel_n
);
  logic [CLAIM_N-1:0] page_en_q;
  logic               rom_en_q;
  logic [CLAIM_N-1:0] page_hit;
  logic               rom_hit;
  logic               claim;

  exp_cfg_reg #(.N(CLAIM_N)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .page_en_d (cfg_page_en),
    .rom_en_d  (cfg_rom_en),
    .page_en_q (page_en_q),
    .rom_en_q  (rom_en_q)
  );

  exp_page_match #(
    .IO_BASE      (IO_BASE),
    .IO_SPAN_BITS (IO_SPAN_BITS),
    .PAGE_BITS    (PAGE_BITS)
  ) u_pages (
    .addr (addr),
    .en   (page_en_q),
    .hit  (page_hit)
  );

  exp_rom_match #(
    .ROM_BASE      (ROM_BASE),
    .ROM_SPAN_BITS (ROM_SPAN_BITS)
  ) u_rom (
    .addr (addr),
    .en   (rom_en_q),
    .hit  (rom_hit)
  );

  assign claim      = (|page_hit) | rom_hit;
  assign page_sel_n = ~(page_hit & {CLAIM_N{~strobe_n}});
  assign rom_sel_n  = ~(rom_hit & ~strobe_n);
  // A claimed access hides the strobe from the motherboard decoder.
  assign ovr_n      = strobe_n | claim;
endmodule

// File: rtl/exp_page_decoder_chk.sv
module exp_page_decoder_chk #(
  parameter int N = 63
) (
  input logic        clk,
  input logic        rst_n,
  input logic [19:0] addr,
  input logic        strobe_n,
  input logic        cfg_load,
  input logic        ovr_n,
  input logic [N-1:0] page_sel_n,
  input logic        rom_sel_n,
  input logic [N-1:0] page_en_q,
  input logic        rom_en_q
);
  logic any_sel;
  assign any_sel = ~(&page_sel_n) | ~rom_sel_n;

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{rom_sel_n, page_sel_n}));

  assert_select_hides_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_sel |-> (ovr_n && !strobe_n));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_n != strobe_n) |-> any_sel);

  assert_idle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |-> (ovr_n && rom_sel_n && (&page_sel_n)));

  assert_reserved_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[19:8] == 12'h180) |-> (ovr_n == strobe_n));

  assert_outside_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[19:14] != 6'h06) |-> (&page_sel_n));

  assert_rom_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_sel_n |-> (addr[19:14] == 6'h03));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(page_en_q) && $stable(rom_en_q)));
endmodule

bind exp_page_decoder exp_page_decoder_chk #(.N(CLAIM_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .strobe_n   (strobe_n),
  .cfg_load   (cfg_load),
  .ovr_n      (ovr_n),
  .page_sel_n (page_sel_n),
  .rom_sel_n  (rom_sel_n),
  .page_en_q  (page_en_q),
  .rom_en_q   (rom_en_q)
);

// File: tb/exp_page_decoder_bench.sv
module exp_page_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] addr;
  logic        strobe_n;
  logic        cfg_load;
  logic [62:0] cfg_page_en;
  logic        cfg_rom_en;
  logic        ovr_n;
  logic [62:0] page_sel_n;
  logic        rom_sel_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  exp_page_decoder u_exp_page_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .strobe_n    (strobe_n),
    .cfg_load    (cfg_load),
    .cfg_page_en (cfg_page_en),
    .cfg_rom_en  (cfg_rom_en),
    .ovr_n       (ovr_n),
    .page_sel_n  (page_sel_n),
    .rom_sel_n   (rom_sel_n)
  );

  // sel: -1 none, 0..62 page slot, 63 ROM select.
  task automatic expect_out(string tag, logic exp_ovr, int sel);
    logic [63:0] exp_v;
    exp_v = '1;
    if (sel >= 0) exp_v[sel] = 1'b0;
    checks++;
    if (ovr_n !== exp_ovr || {rom_sel_n, page_sel_n} !== exp_v) begin
      fails++;
      $display("FAIL %s addr=%05h: ovr_n=%b sel=%016h expected ovr_n=%b sel=%016h",
               tag, addr, ovr_n, {rom_sel_n, page_sel_n}, exp_ovr, exp_v);
    end
  endtask

  task automatic access(logic [19:0] a, logic s);
    @(negedge clk);
    addr = a;
    strobe_n = s;
    #1;
  endtask

  task automatic load_cfg(logic [62:0] m, logic r);
    @(negedge clk);
    cfg_page_en = m;
    cfg_rom_en  = r;
    cfg_load    = 1'b1;
    @(negedge clk);
    cfg_load    = 1'b0;
  endtask

  task automatic t_reset;
    access(20'h18100, 1'b0); expect_out("R1 page1 after reset", 1'b0, -1);
    access(20'h0C000, 1'b0); expect_out("R1 rom after reset", 1'b0, -1);
    access(20'h1BFFF, 1'b1); expect_out("R1 strobe idle", 1'b1, -1);
  endtask

  task automatic t_pass;
    access(20'h00000, 1'b0); expect_out("R2 low addr", 1'b0, -1);
    access(20'hFFFFF, 1'b0); expect_out("R2 top addr", 1'b0, -1);
    access(20'h20000, 1'b1); expect_out("R2 idle", 1'b1, -1);
  endtask

  task automatic t_pages;
    load_cfg('1, 1'b0);
    access(20'h18100, 1'b0); expect_out("R3 page1 base", 1'b1, 0);
    access(20'h182FF, 1'b0); expect_out("R3 page2 top", 1'b1, 1);
    access(20'h19F40, 1'b0); expect_out("R3 page31", 1'b1, 30);
    access(20'h1BFFF, 1'b0); expect_out("R10 page63 last byte", 1'b1, 62);
  endtask

  task automatic t_page0;
    access(20'h18000, 1'b0); expect_out("R4 reserved base", 1'b0, -1);
    access(20'h180FF, 1'b0); expect_out("R4 reserved top", 1'b0, -1);
  endtask

  task automatic t_outside;
    access(20'h17FFF, 1'b0); expect_out("R6 below io", 1'b0, -1);
    access(20'h1C000, 1'b0); expect_out("R6 above io", 1'b0, -1);
    access(20'h1C100, 1'b0); expect_out("R6 above io page1", 1'b0, -1);
  endtask

  task automatic t_strobe;
    access(20'h18500, 1'b1); expect_out("R7 idle on enabled page", 1'b1, -1);
  endtask

  task automatic t_disabled;
    load_cfg(63'h10, 1'b0);
    access(20'h18500, 1'b0); expect_out("R5 enabled page5", 1'b1, 4);
    access(20'h18600, 1'b0); expect_out("R5 disabled page6", 1'b0, -1);
    access(20'h18400, 1'b0); expect_out("R5 disabled page4", 1'b0, -1);
  endtask

  task automatic t_rom;
    load_cfg('0, 1'b1);
    access(20'h0C000, 1'b0); expect_out("R8 rom base", 1'b1, 63);
    access(20'h0FFFF, 1'b0); expect_out("R8 rom top", 1'b1, 63);
    access(20'h0BFFF, 1'b0); expect_out("R8 below rom", 1'b0, -1);
    access(20'h10000, 1'b0); expect_out("R8 above rom", 1'b0, -1);
    access(20'h0C000, 1'b1); expect_out("R8 rom idle", 1'b1, -1);
    load_cfg('0, 1'b0);
    access(20'h0D000, 1'b0); expect_out("R8 rom disabled", 1'b0, -1);
  endtask

  task automatic t_load;
    @(negedge clk);
    cfg_page_en = '1;
    cfg_rom_en  = 1'b1;
    access(20'h18100, 1'b0); expect_out("R9 no load page", 1'b0, -1);
    access(20'h0C000, 1'b0); expect_out("R9 no load rom", 1'b0, -1);
    @(negedge clk);
    cfg_page_en = 63'h1;
    cfg_load    = 1'b1;
    addr        = 20'h18100;
    #1;
    expect_out("R9 before edge", 1'b0, -1);
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
    expect_out("R9 after edge", 1'b1, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    addr = '0;
    strobe_n = 1'b1;
    cfg_load = 1'b0;
    cfg_page_en = '0;
    cfg_rom_en = 1'b0;
    #1;
    expect_out("R1 in reset", 1'b1, -1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_pages();
    t_page0();
    t_outside();
    t_strobe();
    t_disabled();
    t_rom();
    t_load();
    finish_run();
  end
endmodule